// File: doc/BRIEF.md
# Neutral-Point Balancing Offset Calculator

This block runs once per control period of a three-level clamped-neutral inverter. It takes the three signed phase on-time ratios and the three phase currents for the coming period and computes one common-mode offset. The offset is added to every phase, and it is chosen so that the estimated average current drawn from the DC-link midpoint over the period becomes zero. This suppresses the AC ripple between the two halves of the DC link.

Ratios and currents are 16-bit two's-complement values with 14 fractional bits, so 1.0 is 16384. The block ranks the phases by ratio and estimates the midpoint current. It then picks one of the closed-form solutions, chosen by the sign of the middle ratio and the sign the offset must take. A single sequential restoring division follows. The result is clamped so that no phase leaves the modulation range, and the three adjusted ratios are returned with a one-cycle valid strobe. The caller starts a computation with a one-cycle start pulse, and the result arrives a fixed number of cycles later.

Top module: `np_offset_calc`

## Requirements
- R1: While reset is held and after it is released, `valid`, `offset` and the three adjusted ratios are 0 until the first computation completes.
- R2: `valid` is a one-cycle pulse that rises exactly 2·W+6 clock edges (38 by default) after the edge that samples `start`. `offset` and the adjusted ratios change only on the edge that raises `valid` and hold their values otherwise.
- R3: A `start` that arrives while a computation is in progress is ignored: the running result and its timing are unaffected, and no extra `valid` follows.
- R4: Phases are ranked in descending ratio order, with ties resolved in the order a, b, c. The estimated neutral current is inp = Imax·|rmax| + Imid·|rmid| + Imin·|rmin|.
- R5: The offset is required to be positive when inp < 0 and negative otherwise. A middle ratio ≥ 0 counts as positive. When the middle ratio and the required offset share a sign, the raw offset is −inp / DA with DA = Imax − Imin + s·Imid, where s is the middle-ratio sign (±1).
- R6: When the signs differ, the DA solution is kept if |inp| ≤ |rmid|·|DA|. Otherwise the raw offset is −(inp − 2·|rmid|·Imid) / DB with DB = Imax − Imin − s·Imid.
- R7: If the selected denominator has magnitude below 64 (0.0039), the raw offset is 0.
- R8: The quotient is in the 14-fractional-bit format, truncated toward zero, and its magnitude saturates at 32767.
- R9: The raw offset is clamped to hi = 16384 − |rmax| if above it, otherwise to lo = |rmin| − 16384 if below it. The clamped value is driven on `offset`.
- R10: Each adjusted ratio is the phase's input ratio plus `offset`, saturated to the 16-bit signed range instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation with the values on the data inputs |
| ratio_a | input | 16 | Phase a on-time ratio, signed Q1.14 |
| ratio_b | input | 16 | Phase b on-time ratio, signed Q1.14 |
| ratio_c | input | 16 | Phase c on-time ratio, signed Q1.14 |
| cur_a | input | 16 | Phase a current, signed Q1.14 |
| cur_b | input | 16 | Phase b current, signed Q1.14 |
| cur_c | input | 16 | Phase c current, signed Q1.14 |
| valid | output | 1 | One-cycle strobe marking new results |
| out_a | output | 16 | Phase a ratio plus offset, saturated |
| out_b | output | 16 | Phase b ratio plus offset, saturated |
| out_c | output | 16 | Phase c ratio plus offset, saturated |
| offset | output | 16 | Clamped common-mode offset, signed Q1.14 |

## Verification
Every result is due on the 38th rising edge after the edge that samples `start`: one edge for ranking and case selection, 36 for the division, and one for clamping and output. The bench drives `start`, counts rising edges until `valid` is seen 1 ns after an edge, requires that count to equal 38, and only then compares `offset` and the three outputs with a model built from the requirement formulas. It also requires `valid` to be low one cycle later, and the outputs to be unchanged several cycles after that.

// File: rtl/np_offset_calc.sv
module np_offset_calc #(
  parameter int W       = 16,
  parameter int FRAC    = 14,
  parameter int DEN_MIN = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic signed [W-1:0] ratio_a,
  input  logic signed [W-1:0] ratio_b,
  input  logic signed [W-1:0] ratio_c,
  input  logic signed [W-1:0] cur_a,
  input  logic signed [W-1:0] cur_b,
  input  logic signed [W-1:0] cur_c,
  output logic                valid,
  output logic signed [W-1:0] out_a,
  output logic signed [W-1:0] out_b,
  output logic signed [W-1:0] out_c,
  output logic signed [W-1:0] offset
);
  localparam int PW = 2*W + 4;
  localparam int DW = W + 3;
  localparam int RW = W + 2;
  localparam int CW = $clog2(PW);
  localparam logic signed [RW-1:0] ONE  = RW'(1) <<< FRAC;
  localparam logic signed [RW-1:0] MAXQ = RW'((1 << (W-1)) - 1);
  localparam logic signed [RW-1:0] MAXO = RW'((1 << (W-1)) - 1);
  localparam logic signed [RW-1:0] MINO = -RW'(1 << (W-1));

  typedef enum logic [1:0] {IDLE, EST, DIV, OUT} st_t;
  st_t st;
  logic busy;
  assign busy = (st != IDLE);

  logic signed [W-1:0] rq [3];
  logic signed [W-1:0] iq [3];

  // ranking: descending, ties kept in order a, b, c
  logic ge_ab, ge_ac, ge_bc;
  logic [1:0] kmx, kmn, kmd;
  assign ge_ab = rq[0] >= rq[1];
  assign ge_ac = rq[0] >= rq[2];
  assign ge_bc = rq[1] >= rq[2];
  assign kmx = (ge_ab && ge_ac) ? 2'd0 : (!ge_ab && ge_bc) ? 2'd1 : 2'd2;
  assign kmn = (ge_ac && ge_bc) ? 2'd2 : (ge_ab && !ge_bc) ? 2'd1 : 2'd0;
  assign kmd = 2'd3 - kmx - kmn;

  logic signed [W-1:0] rmx, rmd, rmn, imx, imd, imn;
  assign rmx = rq[kmx];
  assign rmd = rq[kmd];
  assign rmn = rq[kmn];
  assign imx = iq[kmx];
  assign imd = iq[kmd];
  assign imn = iq[kmn];

  logic signed [RW-1:0] amx, amd, amn;
  assign amx = (rmx < 0) ? -RW'(rmx) : RW'(rmx);
  assign amd = (rmd < 0) ? -RW'(rmd) : RW'(rmd);
  assign amn = (rmn < 0) ? -RW'(rmn) : RW'(rmn);

  logic signed [PW-1:0] p_mx, p_md, p_mn, inp, nb, n_sel;
  assign p_mx = PW'(imx) * PW'(amx);
  assign p_md = PW'(imd) * PW'(amd);
  assign p_mn = PW'(imn) * PW'(amn);
  assign inp  = p_mx + p_md + p_mn;
  assign nb   = inp - (p_md <<< 1);

  logic mid_pos, off_pos, use_b, zero_d;
  logic signed [DW-1:0] imd_s, da, db, d_sel;
  logic [DW-1:0] d_mag, da_mag;
  logic [PW-1:0] inp_mag, lim_a, n_mag;
  assign mid_pos = (rmd >= 0);
  assign off_pos = (inp < 0);
  assign imd_s   = mid_pos ? DW'(imd) : -DW'(imd);
  assign da      = DW'(imx) - DW'(imn) + imd_s;
  assign db      = DW'(imx) - DW'(imn) - imd_s;
  assign da_mag  = (da < 0) ? DW'(-da) : DW'(da);
  assign inp_mag = (inp < 0) ? PW'(-inp) : PW'(inp);
  assign lim_a   = PW'(amd) * PW'(da_mag);
  assign use_b   = (off_pos != mid_pos) && (inp_mag > lim_a);
  assign n_sel   = use_b ? nb : inp;
  assign d_sel   = use_b ? db : da;
  assign d_mag   = (d_sel < 0) ? DW'(-d_sel) : DW'(d_sel);
  assign n_mag   = (n_sel < 0) ? PW'(-n_sel) : PW'(n_sel);
  assign zero_d  = d_mag < DW'(DEN_MIN);

  logic signed [RW-1:0] hi, lo;
  assign hi = ONE - amx;
  assign lo = amn - ONE;

  // restoring divider
  logic [PW-1:0] quo;
  logic [DW:0]   rem, rem_sh;
  logic [DW-1:0] den;
  logic [CW-1:0] cnt;
  logic          neg;
  assign rem_sh = {rem[DW-1:0], quo[PW-1]};

  logic signed [RW-1:0] qs, raw, cl;
  assign qs  = (quo > PW'(MAXQ)) ? MAXQ : RW'(quo[W-1:0]);
  assign raw = neg ? -qs : qs;
  assign cl  = (raw > hi) ? hi : (raw < lo) ? lo : raw;

  function automatic logic signed [W-1:0] sat(input logic signed [RW-1:0] v);
    return (v > MAXO) ? MAXO[W-1:0] : (v < MINO) ? MINO[W-1:0] : v[W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      valid  <= 1'b0;
      out_a  <= '0;
      out_b  <= '0;
      out_c  <= '0;
      offset <= '0;
      quo    <= '0;
      rem    <= '0;
      den    <= '0;
      cnt    <= '0;
      neg    <= 1'b0;
      for (int k = 0; k < 3; k++) begin
        rq[k] <= '0;
        iq[k] <= '0;
      end
    end else begin
      valid <= 1'b0;
      case (st)
        IDLE: if (start) begin
          rq[0] <= ratio_a; rq[1] <= ratio_b; rq[2] <= ratio_c;
          iq[0] <= cur_a;   iq[1] <= cur_b;   iq[2] <= cur_c;
          st    <= EST;
        end
        EST: begin
          quo <= zero_d ? '0 : n_mag;
          den <= zero_d ? DW'(1) : d_mag;
          neg <= (n_sel < 0) == (d_sel < 0);
          rem <= '0;
          cnt <= '0;
          st  <= DIV;
        end
        DIV: begin
          if (rem_sh >= {1'b0, den}) begin
            rem <= rem_sh - {1'b0, den};
            quo <= {quo[PW-2:0], 1'b1};
          end else begin
            rem <= rem_sh;
            quo <= {quo[PW-2:0], 1'b0};
          end
          cnt <= cnt + 1'b1;
          if (cnt == CW'(PW-1)) st <= OUT;
        end
        default: begin
          offset <= cl[W-1:0];
          out_a  <= sat(RW'(rq[0]) + cl);
          out_b  <= sat(RW'(rq[1]) + cl);
          out_c  <= sat(RW'(rq[2]) + cl);
          valid  <= 1'b1;
          st     <= IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/np_offset_calc_chk.sv
module np_offset_calc_chk #(
  parameter int W    = 16,
  parameter int FRAC = 14,
  parameter int PW   = 36
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                busy,
  input logic                valid,
  input logic signed [W-1:0] offset,
  input logic signed [W-1:0] out_a,
  input logic signed [W-1:0] out_b,
  input logic signed [W-1:0] out_c
);
  localparam int LAT = PW + 2;
  localparam int CW  = $clog2(LAT + 2) + 1;
  localparam logic signed [W-1:0] ONE = W'(1 << FRAC);

  logic [CW-1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)              age <= '0;
    else if (start && !busy) age <= CW'(1);
    else if (valid)          age <= '0;
    else if (age != '0)      age <= age + 1'b1;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> age == CW'(LAT + 1));
  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(offset) && $stable(out_a) && $stable(out_b) && $stable(out_c)));
  p_busy_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || valid));
  p_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (offset <= ONE && offset >= -ONE));
endmodule

bind np_offset_calc np_offset_calc_chk #(.W(W), .FRAC(FRAC), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .valid(valid),
  .offset(offset), .out_a(out_a), .out_b(out_b), .out_c(out_c)
);

// File: tb/test_np_offset_calc.sv
module test_np_offset_calc;
  localparam int LAT = 38;
  localparam int NV  = 10;

  logic clk = 0, rst_n = 0, start = 0;
  logic signed [15:0] ra = 0, rb = 0, rc = 0, ia = 0, ib = 0, ic = 0;
  logic valid;
  logic signed [15:0] oa, ob, oc, off;
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  np_offset_calc i_np_offset_calc (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ratio_a(ra), .ratio_b(rb), .ratio_c(rc),
    .cur_a(ia), .cur_b(ib), .cur_c(ic),
    .valid(valid), .out_a(oa), .out_b(ob), .out_c(oc), .offset(off)
  );

  localparam int VEC [NV][6] = '{
    '{ 10000,  9900,   -300,  3000,  -100, -2900},
    '{ 12000, -3000,  -9000,  5000, -4000, -1000},
    '{ -2000,  9000,  -7000,  3000,  -500, -2500},
    '{  8192,  2000, -10192,  4000, -1000, -3000},
    '{ 14000,     0, -14000, 10000,     0, -9000},
    '{  5000,  5000, -10000,  2000,  1500, -3500},
    '{  6000, -1000,  -7000,  3000,  1000,  2000},
    '{ 10000,  -500,  -9500,  3000,  2900,     0},
    '{ 30000,     0, -32768,  1000,   200, -1200},
    '{  9000, -4000,  -5000, -2000,  3000, -1000}
  };
  localparam string TAG [NV] = '{"R6", "R5", "R6", "R9", "R9", "R4", "R7", "R8", "R10", "R5"};

  function automatic longint ab(longint v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int satw(longint v);
    return (v > 32767) ? 32767 : (v < -32768) ? -32768 : int'(v);
  endfunction

  function automatic void model(input int v[6], output int eo, output int e[3]);
    int ix[3];
    int t;
    longint inp, da, db, ims, nb, n, d, q, r, hi, lo, c;
    bit sm, sp, useb;
    ix = '{0, 1, 2};
    for (int p = 0; p < 2; p++)
      for (int j = 0; j < 2; j++)
        if (v[ix[j]] < v[ix[j+1]]) begin t = ix[j]; ix[j] = ix[j+1]; ix[j+1] = t; end
    inp = longint'(v[3+ix[0]]) * ab(v[ix[0]]) + longint'(v[3+ix[1]]) * ab(v[ix[1]])
        + longint'(v[3+ix[2]]) * ab(v[ix[2]]);
    sm  = v[ix[1]] >= 0;
    sp  = inp < 0;
    ims = sm ? v[3+ix[1]] : -v[3+ix[1]];
    da  = longint'(v[3+ix[0]]) - v[3+ix[2]] + ims;
    db  = longint'(v[3+ix[0]]) - v[3+ix[2]] - ims;
    nb  = inp - 2 * ab(v[ix[1]]) * v[3+ix[1]];
    useb = (sp != sm) && (ab(inp) > ab(v[ix[1]]) * ab(da));
    n = useb ? nb : inp;
    d = useb ? db : da;
    if (ab(d) < 64) r = 0;
    else begin
      q = ab(n) / ab(d);
      if (q > 32767) q = 32767;
      r = ((n < 0) == (d < 0)) ? -q : q;
    end
    hi = 16384 - ab(v[ix[0]]);
    lo = ab(v[ix[2]]) - 16384;
    c  = (r > hi) ? hi : (r < lo) ? lo : r;
    eo = int'(c);
    for (int k = 0; k < 3; k++) e[k] = satw(longint'(v[k]) + c);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(int v[6]);
    ra = 16'(v[0]); rb = 16'(v[1]); rc = 16'(v[2]);
    ia = 16'(v[3]); ib = 16'(v[4]); ic = 16'(v[5]);
  endtask

  task automatic wait_valid(output int lat);
    lat = 0;
    while (!valid && lat < 200) begin
      @(posedge clk); #1;
      lat++;
    end
  endtask

  task automatic compare(int v[6], string tag);
    int eo; int e[3];
    model(v, eo, e);
    check({tag, " offset"}, off, eo);
    check({tag, " out_a"}, oa, e[0]);
    check({tag, " out_b"}, ob, e[1]);
    check({tag, " out_c"}, oc, e[2]);
  endtask

  task automatic run(int v[6], string tag);
    int lat;
    @(negedge clk);
    drive(v);
    start = 1;
    @(posedge clk); #1;
    start = 0;
    wait_valid(lat);
    check("R2 latency", lat, LAT);
    compare(v, tag);
    @(posedge clk); #1;
    check("R2 pulse", valid, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat, keep;
    int e[3];
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", valid, 0);
    check("R1 offset in reset", off, 0);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid after reset", valid, 0);
    check("R1 out_a after reset", oa, 0);
    check("R1 out_c after reset", oc, 0);

    for (int k = 0; k < NV; k++) run(VEC[k], TAG[k]);

    keep = off;
    repeat (5) @(posedge clk);
    #1;
    check("R2 hold offset", off, keep);

    // R3: a second start during the computation is ignored
    @(negedge clk);
    drive(VEC[1]);
    start = 1;
    @(posedge clk); #1;
    start = 0;
    repeat (5) @(posedge clk);
    #1;
    drive(VEC[2]);
    start = 1;
    @(posedge clk); #1;
    start = 0;
    wait_valid(lat);
    check("R3 latency kept", lat + 6, LAT);
    compare(VEC[1], "R3");
    keep = 0;
    for (int k = 0; k < LAT + 4; k++) begin
      @(posedge clk); #1;
      if (valid) keep++;
    end
    check("R3 no extra valid", keep, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule